// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block prepares one interrupt pin from outside the chip for the system interrupt controller. The raw pin is first passed through a chain of synchronising flip-flops. Its sense is then corrected so that "asserted" always means logic 1. A detector then turns the corrected signal into a pending-request status bit, which drives the single request line to the controller.

Software uses a small control word to choose between two detection styles. In level detection the status simply tracks the corrected pin. In edge detection an inactive-to-active transition sets a sticky status bit, which stays set until software writes a one to a self-clearing clear bit. If a new edge and a clear land in the same cycle, the edge wins, so no request can be lost.

The control word has four bits. Bit 0 selects the detection style (0 level, 1 edge). Bit 1 selects the pin sense (0 active high, 1 active low). Bit 2 is the write-one clear. Bit 3 is the read-only pending status.

Top module: `ext_irq_cond`

## Requirements
- R1: After synchronous reset the read word is 0 (level detection, active-high pin, nothing pending) and `irq_out` is 0.
- R2: A write stores bit 0 (detection style) and bit 1 (pin sense), which read back unchanged from the next cycle. Bit 2 always reads 0. Bit 3 cannot be written.
- R3: In level detection with an active-high pin, `irq_out` equals the pin as it was three clock edges earlier: two synchroniser stages plus the status register.
- R4: In level detection with an active-low pin (bit 1 = 1), `irq_out` is the inverse of the pin, with the same three-edge latency.
- R5: In edge detection, an inactive-to-active transition of the corrected pin sets the status. The status stays set after the pin returns to inactive.
- R6: In edge detection, a write with bit 2 = 1 clears the status at that clock edge. A write with bit 2 = 0 leaves the status unchanged.
- R7: In edge detection, when a clear write and a detected transition fall in the same cycle, the status ends up set.
- R8: In level detection, writing bit 2 = 1 has no effect on the status.
- R9: `irq_out` always equals read bit 3.
- R10: In edge detection with an active-low pin, a falling pin sets the status and a rising pin does not.
- R11: In edge detection, a corrected pin held active after a clear does not set the status again. Only a new transition does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Asynchronous external interrupt pin |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 4 | Control word write value |
| rd_data | output | 4 | Control word read value, including status |
| irq_out | output | 1 | Interrupt request to the controller |

## Verification
The hardest case to reach is a clear write that lands in exactly the cycle the detector sees a new edge. That cycle is hidden behind the two synchroniser stages. The bench drives the pin on a falling clock edge and counts two rising edges. It then raises the clear write so that it is sampled on the third rising edge, the same edge on which the detector registers the transition. The status must then read as set.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int CTRL_W   = 4;
    localparam int BIT_MODE = 0;
    localparam int BIT_POL  = 1;
    localparam int BIT_CLR  = 2;
    localparam int BIT_STS  = 3;

    typedef enum logic {
        DET_LEVEL = 1'b0,
        DET_EDGE  = 1'b1
    } det_mode_e;

    typedef enum logic {
        POL_HIGH = 1'b0,
        POL_LOW  = 1'b1
    } pin_pol_e;

    typedef struct packed {
        pin_pol_e  pol;
        det_mode_e mode;
    } irq_ctrl_t;

    localparam irq_ctrl_t CTRL_RESET = '{pol: POL_HIGH, mode: DET_LEVEL};

    // Corrects the synchronised pin so that 1 always means "asserted".
    function automatic logic to_active(logic raw, pin_pol_e pol);
        return raw ^ (pol == POL_LOW);
    endfunction

    // Builds the software-visible word; the clear bit always reads 0.
    function automatic logic [CTRL_W-1:0] pack_view(irq_ctrl_t c, logic sts);
        logic [CTRL_W-1:0] v;
        v           = '0;
        v[BIT_MODE] = c.mode;
        v[BIT_POL]  = c.pol;
        v[BIT_STS]  = sts;
        return v;
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b0;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              sts,
    output irq_ctrl_t         ctrl,
    output logic              clr,
    output logic [CTRL_W-1:0] rd_data
);

    irq_ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
        end else if (wr_en) begin
            ctrl_q.mode <= det_mode_e'(wr_data[BIT_MODE]);
            ctrl_q.pol  <= pin_pol_e'(wr_data[BIT_POL]);
        end
    end

    // The clear bit is not stored: it acts for the cycle of the write only.
    assign clr     = wr_en & wr_data[BIT_CLR];
    assign ctrl    = ctrl_q;
    assign rd_data = pack_view(ctrl_q, sts);

endmodule

// File: rtl/irqc_detect.sv
module irqc_detect
    import irqc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      raw_sync,
    input  irq_ctrl_t ctrl,
    input  logic      clr,
    output logic      status
);

    logic act;
    logic prev_q;
    logic status_q;
    logic rise;

    assign act  = to_active(raw_sync, ctrl.pol);
    assign rise = act & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= 1'b0;
            status_q <= 1'b0;
        end else begin
            prev_q <= act;
            unique case (ctrl.mode)
                DET_LEVEL: status_q <= act;
                DET_EDGE: begin
                    if (rise)     status_q <= 1'b1;
                    else if (clr) status_q <= 1'b0;
                end
                default: status_q <= status_q;
            endcase
        end
    end

    assign status = status_q;

    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == DET_LEVEL) |=> (status_q == $past(act))); // R3

    AST_EDGE_SET: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == DET_EDGE && rise) |=> status_q); // R7

    AST_EDGE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == DET_EDGE && clr && !rise) |=> !status_q); // R6

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == DET_EDGE && !clr && !rise) |=> $stable(status_q)); // R11

endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
    import irqc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_in,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    output logic              irq_out
);

    logic      pin_sync;
    logic      clr;
    logic      status;
    irq_ctrl_t ctrl;

    irqc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    irqc_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .sts     (status),
        .ctrl    (ctrl),
        .clr     (clr),
        .rd_data (rd_data)
    );

    irqc_detect u_detect (
        .clk      (clk),
        .rst      (rst),
        .raw_sync (pin_sync),
        .ctrl     (ctrl),
        .clr      (clr),
        .status   (status)
    );

    assign irq_out = status;

    AST_CTRL_READBACK: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[BIT_POL:BIT_MODE] == $past(wr_data[BIT_POL:BIT_MODE]))); // R2

endmodule

// File: tb/test_ext_irq_cond.sv
module test_ext_irq_cond;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = 4'h0;
    logic [3:0] rd_data;
    logic       irq_out;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    ext_irq_cond i_ext_irq_cond (
        .clk     (clk),
        .rst     (rst),
        .pin_in  (pin_in),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq_out (irq_out)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Wait n rising edges, then settle on the following falling edge.
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // One-cycle write; returns on the falling edge after the write took effect.
    task automatic write_ctrl(input logic [3:0] v);
        wr_en   = 1'b1;
        wr_data = v;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = 4'h0;
    endtask

    task automatic settle_idle();
        pin_in = 1'b0;
        write_ctrl(4'b0000);
        tick(4);
    endtask

    task automatic t_reset();
        check("R1 rd_data", rd_data, 4'h0);
        check("R1 irq_out", {3'b0, irq_out}, 4'h0);
    endtask

    task automatic t_regs();
        write_ctrl(4'b1110);
        check("R2 fields after 1110", {1'b0, rd_data[2:0]}, 4'b0010);
        write_ctrl(4'b0001);
        check("R2 fields after 0001", {1'b0, rd_data[2:0]}, 4'b0001);
        settle_idle();
        check("R2 status not writable", {3'b0, rd_data[3]}, 4'h0);
    endtask

    task automatic t_level_high();
        settle_idle();
        pin_in = 1'b1;
        tick(2);
        check("R3 latency not yet", {3'b0, irq_out}, 4'h0);
        tick(1);
        check("R3 high follows", {3'b0, irq_out}, 4'h1);
        check("R9 status equals irq", {3'b0, rd_data[3]}, {3'b0, irq_out});
        pin_in = 1'b0;
        tick(3);
        check("R3 low follows", {3'b0, irq_out}, 4'h0);
    endtask

    task automatic t_level_low();
        settle_idle();
        write_ctrl(4'b0010);
        tick(3);
        check("R4 low pin asserts", {3'b0, irq_out}, 4'h1);
        pin_in = 1'b1;
        tick(3);
        check("R4 high pin deasserts", {3'b0, irq_out}, 4'h0);
        check("R9 status equals irq", {3'b0, rd_data[3]}, {3'b0, irq_out});
    endtask

    task automatic t_edge_and_clear();
        settle_idle();
        write_ctrl(4'b0001);
        tick(3);
        check("R5 idle edge mode", {3'b0, irq_out}, 4'h0);
        pin_in = 1'b1;
        tick(3);
        check("R5 rise sets", {3'b0, irq_out}, 4'h1);
        pin_in = 1'b0;
        tick(3);
        check("R5 sticky after release", {3'b0, irq_out}, 4'h1);
        write_ctrl(4'b0001);
        check("R6 write without clear keeps", {3'b0, irq_out}, 4'h1);
        write_ctrl(4'b0101);
        check("R6 clear write clears", {3'b0, irq_out}, 4'h0);
        check("R9 status equals irq", {3'b0, rd_data[3]}, {3'b0, irq_out});
        pin_in = 1'b1;
        tick(3);
        check("R11 new rise sets", {3'b0, irq_out}, 4'h1);
        write_ctrl(4'b0101);
        tick(5);
        check("R11 held level no reset", {3'b0, irq_out}, 4'h0);
    endtask

    task automatic t_edge_wins();
        settle_idle();
        write_ctrl(4'b0101);
        tick(2);
        pin_in = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = 4'b0101;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = 4'h0;
        check("R7 edge beats clear", {3'b0, irq_out}, 4'h1);
        tick(2);
        check("R7 stays set", {3'b0, irq_out}, 4'h1);
    endtask

    task automatic t_level_noclr();
        settle_idle();
        pin_in = 1'b1;
        tick(3);
        write_ctrl(4'b0100);
        check("R8 clear ignored", {3'b0, irq_out}, 4'h1);
        tick(1);
        check("R8 clear ignored later", {3'b0, irq_out}, 4'h1);
    endtask

    task automatic t_edge_low();
        settle_idle();
        pin_in = 1'b1;
        tick(3);
        write_ctrl(4'b0011);
        tick(1);
        write_ctrl(4'b0111);
        tick(2);
        check("R10 cleared start", {3'b0, irq_out}, 4'h0);
        pin_in = 1'b0;
        tick(3);
        check("R10 falling pin sets", {3'b0, irq_out}, 4'h1);
        write_ctrl(4'b0111);
        pin_in = 1'b1;
        tick(4);
        check("R10 rising pin ignored", {3'b0, irq_out}, 4'h0);
    endtask

    initial begin
        fork
            begin
                tick(3);
                rst = 1'b0;
                tick(1);
                t_reset();
                t_regs();
                t_level_high();
                t_level_low();
                t_edge_and_clear();
                t_edge_wins();
                t_level_noclr();
                t_edge_low();
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule